// File: doc/BRIEF.md
# Ringing Cadence Control Sequencer

This block sequences ring bursts and silent intervals for a line interface device. It drives three outputs: an active-low ring-select bit, a 20 Hz square-wave ringing drive and a battery-polarity bit. It runs from a 1 ms tick. The cadence is programmed in whole ringing cycles of 50 ms. When a burst begins, the square wave is started one or two cycles before ring-select goes low. When a burst ends, the square wave is removed first, and ring-select stays low for one more full cycle. This skew keeps the loop-current detector from seeing a false transition.

A ring-trip input ends a burst early. It uses the same exit skew and leaves the line in the active high-battery state. A stop request ends the cadence. The stop can leave the line in the scan state if the configuration asks for it. Polarity is captured while the sequencer is idle and is held for the whole run, so entering or leaving ringing never reverses the battery. A one-cycle strobe marks every change of ring-select or polarity. A downstream filter uses this strobe to blank loop status.

Top module: `ring_cadence_seq`

## Requirements
- R1: After reset, ring_n is 1, sq_drive is 0, pol_fwd is 1 (with rev_mode low), scan_sel is 0 and xfer_strobe is 0.
- R2: While the square wave runs, its period is 2*HALF_TICKS ticks. Each cycle starts high, and sq_drive stays high for exactly HALF_TICKS ticks.
- R3: After start, sq_drive runs for 2 whole cycles before ring_n falls, or for 1 cycle when lead_one is 1. At the moment ring_n falls, sq_drive is high.
- R4: At the end of a normal burst, sq_drive stops at the cycle boundary. ring_n then stays low for one further full cycle, and sq_drive stays 0 during that cycle. As a result, ring_n rises 3*HALF_TICKS ticks after the last falling edge of sq_drive.
- R5: A burst keeps ring_n low for (on_cycles+1) full cycles. The extra cycle is the exit hold. A value of 0 counts as 1. Next comes a silent interval with ring_n high and sq_drive 0 for off_cycles cycles (0 counts as 1), then a new lead. This repeats until stop.
- R6: A ring_trip during the burst stops sq_drive on the next clock. ring_n then rises exactly 2*HALF_TICKS ticks after the trip is sampled, and the block goes idle with scan_sel 0. A ring_trip during the lead returns the block to idle at once, and ring_n never falls. A ring_trip during the silent interval or while idle is ignored.
- R7: A stop during the silent interval or the lead returns the block to idle at once. A stop during the burst uses the ring-trip exit timing of R6. After a stop, scan_sel equals scan_exit.
- R8: While idle, pol_fwd equals the inverse of rev_mode (1 forward, 0 reverse). pol_fwd holds its value from start until the block is idle again, even if rev_mode changes during the run.
- R9: xfer_strobe is high for one clock in exactly those cycles in which ring_n or pol_fwd has just taken a new value.
- R10: scan_sel is 0 whenever ring_n is low or sq_drive is high. It equals scan_exit during a silent interval.
- R11: A start pulse while a cadence is running has no effect on burst timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse every 1 ms |
| start | input | 1 | Begin cadence (pulse) |
| stop | input | 1 | End cadence (pulse) |
| ring_trip | input | 1 | Off-hook during ringing detected (pulse) |
| rev_mode | input | 1 | 1 selects reverse-battery operation |
| lead_one | input | 1 | 1 shortens the entry lead to one cycle |
| scan_exit | input | 1 | 1 ends normal ringing in scan state |
| on_cycles | input | CYC_W | Burst length in ringing cycles |
| off_cycles | input | CYC_W | Silent length in ringing cycles |
| ring_n | output | 1 | Ring-select, low while ringing |
| sq_drive | output | 1 | Square-wave ringing drive |
| pol_fwd | output | 1 | Battery polarity, 1 forward, 0 reverse |
| scan_sel | output | 1 | Scan state selected instead of active |
| xfer_strobe | output | 1 | One-cycle strobe on ring_n or pol_fwd change |

## Verification
The hardest case to reach is an early exit that lands in the middle of a ringing cycle. The exit hold must then restart from the trip rather than from the cycle boundary, and the bench can only see this from the tick distance to the rise of ring_n. The bench waits for the fall of ring_n and lets a few ticks pass. It then pulses ring_trip or stop and measures the ticks to the rise. A sweep over lead, burst, silent, polarity and scan settings with a three-tick half period then covers every cadence edge. That sweep also carries stray start and trip pulses at points in the cadence where they must be ignored.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BURST,
        ST_LAG,
        ST_SILENT
    } rcs_state_e;

    // ring-select is low in these phases
    function automatic logic ring_active(rcs_state_e s);
        return (s == ST_BURST) || (s == ST_LAG);
    endfunction

    // square wave may be present in these phases
    function automatic logic wave_window(rcs_state_e s);
        return (s == ST_LEAD) || (s == ST_BURST);
    endfunction

endpackage

// File: rtl/rcs_wave_gen.sv
module rcs_wave_gen #(
    parameter int HALF_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic level,
    output logic cyc_done
);
    localparam int FULL = 2 * HALF_TICKS;
    localparam int PW   = (FULL > 1) ? $clog2(FULL) : 1;

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (!run || restart) begin
            ph_d = '0;
        end else if (tick) begin
            ph_d = (ph_q == PW'(FULL - 1)) ? '0 : ph_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign level    = (ph_q < PW'(HALF_TICKS));
    assign cyc_done = run && !restart && tick && (ph_q == PW'(FULL - 1));

endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
    import rcs_pkg::*;
#(
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_done,
    input  logic             start,
    input  logic             stop,
    input  logic             ring_trip,
    input  logic             rev_mode,
    input  logic             lead_one,
    input  logic             scan_exit,
    input  logic [CYC_W-1:0] on_cycles,
    input  logic [CYC_W-1:0] off_cycles,
    output rcs_state_e       state,
    output logic             restart,
    output logic             pol_fwd,
    output logic             scan_sel,
    output logic             xfer_strobe
);
    typedef struct packed {
        rcs_state_e       st;
        logic [CYC_W-1:0] cyc;
        logic             pol;
        logic             scan;
        logic             strobe;
        logic             end_req;
        logic             tripped;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [CYC_W-1:0] lead_lim, on_lim, off_lim;
    logic             cyc_last;

    always_comb begin
        lead_lim = lead_one ? CYC_W'(1) : CYC_W'(2);
        on_lim   = (on_cycles  == '0) ? CYC_W'(1) : on_cycles;
        off_lim  = (off_cycles == '0) ? CYC_W'(1) : off_cycles;
    end

    always_comb begin
        logic [CYC_W-1:0] lim;
        logic             end_now, trip_now;
        s_d        = s_q;
        s_d.strobe = 1'b0;
        restart    = 1'b0;
        end_now    = 1'b0;
        trip_now   = 1'b0;
        unique case (s_q.st)
            ST_LEAD:   lim = lead_lim;
            ST_BURST:  lim = on_lim;
            ST_SILENT: lim = off_lim;
            default:   lim = CYC_W'(1);
        endcase
        cyc_last = (s_q.cyc == lim - CYC_W'(1));

        unique case (s_q.st)
            ST_IDLE: begin
                s_d.pol = ~rev_mode;
                if (start) begin
                    s_d.st      = ST_LEAD;
                    s_d.cyc     = '0;
                    s_d.scan    = 1'b0;
                    s_d.end_req = 1'b0;
                    s_d.tripped = 1'b0;
                end
            end
            ST_LEAD: begin
                if (ring_trip) begin
                    s_d.st   = ST_IDLE;
                    s_d.scan = 1'b0;
                end else if (stop) begin
                    s_d.st   = ST_IDLE;
                    s_d.scan = scan_exit;
                end else if (cyc_done) begin
                    s_d.cyc = cyc_last ? '0 : s_q.cyc + CYC_W'(1);
                    if (cyc_last) s_d.st = ST_BURST;
                end
            end
            ST_BURST: begin
                if (ring_trip || stop) begin
                    // cut the wave mid-cycle and hold ring for a fresh cycle
                    s_d.st      = ST_LAG;
                    s_d.cyc     = '0;
                    s_d.end_req = 1'b1;
                    s_d.tripped = ring_trip;
                    restart     = 1'b1;
                end else if (cyc_done) begin
                    s_d.cyc = cyc_last ? '0 : s_q.cyc + CYC_W'(1);
                    if (cyc_last) s_d.st = ST_LAG;
                end
            end
            ST_LAG: begin
                end_now  = s_q.end_req || stop || ring_trip;
                trip_now = s_q.tripped || ring_trip;
                s_d.end_req = end_now;
                s_d.tripped = trip_now;
                if (cyc_done) begin
                    s_d.st   = end_now ? ST_IDLE : ST_SILENT;
                    s_d.cyc  = '0;
                    s_d.scan = trip_now ? 1'b0 : scan_exit;
                end
            end
            ST_SILENT: begin
                if (stop) begin
                    s_d.st   = ST_IDLE;
                    s_d.scan = scan_exit;
                end else if (cyc_done) begin
                    s_d.cyc = cyc_last ? '0 : s_q.cyc + CYC_W'(1);
                    if (cyc_last) begin
                        s_d.st   = ST_LEAD;
                        s_d.scan = 1'b0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        s_d.strobe = (ring_active(s_d.st) != ring_active(s_q.st)) ||
                     (s_d.pol != s_q.pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cyc: '0, pol: 1'b1, scan: 1'b0,
                     strobe: 1'b0, end_req: 1'b0, tripped: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state       = s_q.st;
    assign pol_fwd     = s_q.pol;
    assign scan_sel    = s_q.scan;
    assign xfer_strobe = s_q.strobe;

endmodule

// File: rtl/ring_cadence_seq.sv
module ring_cadence_seq
    import rcs_pkg::*;
#(
    parameter int HALF_TICKS = 25,
    parameter int CYC_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             ring_trip,
    input  logic             rev_mode,
    input  logic             lead_one,
    input  logic             scan_exit,
    input  logic [CYC_W-1:0] on_cycles,
    input  logic [CYC_W-1:0] off_cycles,
    output logic             ring_n,
    output logic             sq_drive,
    output logic             pol_fwd,
    output logic             scan_sel,
    output logic             xfer_strobe
);
    rcs_state_e state;
    logic       restart, level, cyc_done, run;

    assign run = (state != ST_IDLE);

    rcs_wave_gen #(.HALF_TICKS(HALF_TICKS)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .restart  (restart),
        .level    (level),
        .cyc_done (cyc_done)
    );

    rcs_fsm #(.CYC_W(CYC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_done    (cyc_done),
        .start       (start),
        .stop        (stop),
        .ring_trip   (ring_trip),
        .rev_mode    (rev_mode),
        .lead_one    (lead_one),
        .scan_exit   (scan_exit),
        .on_cycles   (on_cycles),
        .off_cycles  (off_cycles),
        .state       (state),
        .restart     (restart),
        .pol_fwd     (pol_fwd),
        .scan_sel    (scan_sel),
        .xfer_strobe (xfer_strobe)
    );

    assign ring_n   = ~ring_active(state);
    assign sq_drive = wave_window(state) && level;

endmodule

// File: rtl/rcs_chk.sv
module rcs_chk (
    input logic clk,
    input logic rst_n,
    input logic ring_n,
    input logic sq_drive,
    input logic pol_fwd,
    input logic scan_sel,
    input logic xfer_strobe
);
    // R9
    strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe == ((ring_n != $past(ring_n)) || (pol_fwd != $past(pol_fwd))));

    // R3
    entry_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ring_n) |-> sq_drive);

    // R4
    exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_n) |-> !sq_drive);

    // R8
    pol_hold_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_n |=> $stable(pol_fwd));

    // R8
    pol_hold_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_drive |=> $stable(pol_fwd));

    // R10
    scan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_n || sq_drive) |-> !scan_sel);
endmodule

bind ring_cadence_seq rcs_chk u_rcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_n      (ring_n),
    .sq_drive    (sq_drive),
    .pol_fwd     (pol_fwd),
    .scan_sel    (scan_sel),
    .xfer_strobe (xfer_strobe)
);

// File: tb/ring_cadence_seq_test.sv
module ring_cadence_seq_test;
    localparam int H    = 3;
    localparam int FULL = 2 * H;
    localparam int TDIV = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic start = 1'b0, stop = 1'b0, ring_trip = 1'b0;
    logic rev_mode = 1'b0, lead_one = 1'b0, scan_exit = 1'b0;
    logic [7:0] on_cycles = 8'd1, off_cycles = 8'd1;
    logic ring_n, sq_drive, pol_fwd, scan_sel, xfer_strobe;

    ring_cadence_seq #(.HALF_TICKS(H), .CYC_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
        .ring_trip(ring_trip), .rev_mode(rev_mode), .lead_one(lead_one),
        .scan_exit(scan_exit), .on_cycles(on_cycles), .off_cycles(off_cycles),
        .ring_n(ring_n), .sq_drive(sq_drive), .pol_fwd(pol_fwd),
        .scan_sel(scan_sel), .xfer_strobe(xfer_strobe)
    );

    always #10 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit done = 0;
    int tcount = 0, rises = 0, falls = 0;
    int t_lead, t_rise, t_fall, t_sqrise, t_sqfall, t_trip, span_last;
    bit arm_lead = 0, have_rise = 0, trip_mode = 0, sq_after = 0, running = 0;
    int pol_flips = 0;
    int cur_lead = 2, cur_on = 1, cur_off = 1;
    bit cur_scan = 0, exp_exit_scan = 0;
    string exit_tag = "R6";
    logic psq = 1'b0, pring = 1'b1, ppol = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor and tick generator, one process at the falling edge
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tick) tcount++;
                if ((ring_trip || stop) && !ring_n && !trip_mode) begin
                    trip_mode = 1; t_trip = tcount; sq_after = 0;
                end
                if (trip_mode && sq_drive) sq_after = 1;
                if (sq_drive && !psq) begin
                    t_sqrise = tcount;
                    if (arm_lead) begin
                        t_lead = tcount; arm_lead = 0;
                        // R5 silent length
                        if (have_rise) chk(t_lead - t_rise == cur_off * FULL, "R5",
                                           t_lead - t_rise, cur_off * FULL);
                    end
                end
                if (!sq_drive && psq) begin
                    // R2 high half length
                    if (!(ring_trip || stop) && !trip_mode)
                        chk(tcount - t_sqrise == H, "R2", tcount - t_sqrise, H);
                    t_sqfall = tcount;
                end
                if (!ring_n && pring) begin
                    falls++;
                    chk(tcount - t_lead == cur_lead * FULL, "R3", tcount - t_lead, cur_lead * FULL);
                    chk(sq_drive == 1'b1, "R3", sq_drive, 1);
                    chk(scan_sel == 1'b0, "R10", scan_sel, 0);
                    t_fall = tcount;
                end
                if (ring_n && !pring) begin
                    rises++;
                    span_last = tcount - t_fall;
                    if (trip_mode) begin
                        chk(tcount - t_trip == FULL, exit_tag, tcount - t_trip, FULL);
                        chk(!sq_after, exit_tag, sq_after, 0);
                        chk(scan_sel == exp_exit_scan, exit_tag, scan_sel, exp_exit_scan);
                        trip_mode = 0; have_rise = 0;
                    end else begin
                        chk(span_last == (cur_on + 1) * FULL, "R5", span_last, (cur_on + 1) * FULL);
                        chk(tcount - t_sqfall == 3 * H, "R4", tcount - t_sqfall, 3 * H);
                        chk(scan_sel == cur_scan, "R10", scan_sel, cur_scan);
                        have_rise = 1; arm_lead = 1; t_rise = tcount;
                    end
                end
                if (xfer_strobe || (ring_n != pring) || (pol_fwd != ppol))
                    chk(xfer_strobe == ((ring_n != pring) || (pol_fwd != ppol)), "R9",
                        xfer_strobe, (ring_n != pring) || (pol_fwd != ppol));
                if (running && (pol_fwd != ppol)) pol_flips++;
            end
            psq = sq_drive; pring = ring_n; ppol = pol_fwd;
            div = (div + 1) % TDIV;
            tick <= (div == 0) && rst_n;
        end
    end

    task automatic wait_ticks(input int n);
        int target = tcount + n;
        while (tcount < target) @(negedge clk);
    endtask
    task automatic wait_rises(input int n);
        int target = rises + n;
        while (rises < target) @(negedge clk);
    endtask
    task automatic wait_falls(input int n);
        int target = falls + n;
        while (falls < target) @(negedge clk);
    endtask
    task automatic pulse_start();
        @(negedge clk); start <= 1'b1; @(negedge clk); start <= 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop <= 1'b1; @(negedge clk); stop <= 1'b0;
    endtask
    task automatic pulse_trip();
        @(negedge clk); ring_trip <= 1'b1; @(negedge clk); ring_trip <= 1'b0;
    endtask

    task automatic setup(input int l1, input int on, input int off, input int rv, input int sx);
        @(negedge clk);
        lead_one <= l1[0]; on_cycles <= 8'(on); off_cycles <= 8'(off);
        rev_mode <= rv[0]; scan_exit <= sx[0];
        cur_lead = l1 ? 1 : 2; cur_on = on; cur_off = off; cur_scan = sx[0];
        repeat (3) @(negedge clk);
        chk(pol_fwd == !rv[0], "R8", pol_fwd, !rv[0]);
        arm_lead = 1; have_rise = 0; trip_mode = 0; pol_flips = 0; running = 1;
    endtask

    task automatic run_cfg(input int l1, input int on, input int off, input int rv, input int sx);
        setup(l1, on, off, rv, sx);
        pulse_start();
        wait_falls(1);
        wait_ticks(2);
        pulse_start();  // stray start inside the burst
        wait_rises(1);
        // R11 burst timing unaffected by the stray start
        chk(span_last == (on + 1) * FULL, "R11", span_last, (on + 1) * FULL);
        wait_rises(1);
        wait_ticks(1);
        running = 0;
        chk(pol_flips == 0, "R8", pol_flips, 0);
        pulse_stop();
        wait_ticks(3 * FULL);
        chk(ring_n == 1'b1 && sq_drive == 1'b0, "R7", {ring_n, sq_drive}, 2);
        chk(scan_sel == sx[0], "R7", scan_sel, sx);
    endtask

    initial begin
        int fb;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(ring_n == 1'b1, "R1", ring_n, 1);
        chk(sq_drive == 1'b0, "R1", sq_drive, 0);
        chk(pol_fwd == 1'b1, "R1", pol_fwd, 1);
        chk(scan_sel == 1'b0 && xfer_strobe == 1'b0, "R1", {scan_sel, xfer_strobe}, 0);
        rst_n <= 1'b1;
        repeat (4) @(negedge clk);

        for (int l1 = 0; l1 < 2; l1++)
            for (int on = 1; on <= 3; on++)
                for (int off = 1; off <= 2; off++)
                    for (int rv = 0; rv < 2; rv++)
                        run_cfg(l1, on, off, rv, (on + rv) % 2);

        // ring trip mid-burst
        setup(1, 3, 1, 0, 1);
        exit_tag = "R6"; exp_exit_scan = 0;
        pulse_start();
        wait_falls(1); wait_ticks(4);
        pulse_trip();
        wait_rises(1); fb = falls;
        wait_ticks(2 * FULL);
        chk(ring_n && !sq_drive && !scan_sel, "R6", {ring_n, sq_drive, scan_sel}, 4);
        chk(falls == fb, "R6", falls, fb);
        running = 0;

        // stop mid-burst
        setup(0, 3, 1, 1, 1);
        exit_tag = "R7"; exp_exit_scan = 1;
        pulse_start();
        wait_falls(1); wait_ticks(2);
        pulse_stop();
        wait_rises(1); fb = falls;
        wait_ticks(2 * FULL);
        chk(falls == fb && scan_sel == 1'b1, "R7", {falls == fb, scan_sel}, 3);
        running = 0;

        // ring trip during lead
        setup(0, 1, 1, 0, 1);
        fb = falls;
        pulse_start();
        wait_ticks(2);
        pulse_trip();
        @(negedge clk);
        chk(sq_drive == 1'b0 && ring_n == 1'b1, "R6", {sq_drive, ring_n}, 1);
        wait_ticks(3 * FULL);
        chk(falls == fb && scan_sel == 1'b0, "R6", falls - fb, 0);
        running = 0;

        // ring trip during silent is ignored
        setup(1, 1, 2, 0, 0);
        pulse_start();
        wait_rises(1); wait_ticks(2);
        pulse_trip();
        wait_falls(1);
        chk(t_lead - t_rise == 2 * FULL, "R6", t_lead - t_rise, 2 * FULL);
        wait_rises(1); wait_ticks(1);
        pulse_stop();
        running = 0;
        wait_ticks(FULL);

        // rev_mode change during run must not move polarity
        setup(1, 2, 1, 1, 0);
        pulse_start();
        wait_falls(1);
        @(negedge clk); rev_mode <= 1'b0;
        wait_rises(1); wait_ticks(1);
        chk(pol_fwd == 1'b0 && pol_flips == 0, "R8", pol_fwd, 0);
        running = 0;
        pulse_stop();
        wait_ticks(2);
        chk(pol_fwd == 1'b1, "R8", pol_fwd, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule